// File: doc/BRIEF.md
# Audio Control Register Slave on I2C

This block is the write-only control port of an audio tone and volume processor. It watches the two I2C lines (SCL and SDA) with its own system clock, finds START and STOP conditions, and assembles bytes from the bit stream. A transfer opens with a fixed device address byte. Next comes a subaddress byte that picks one of eight 8-bit control registers and says whether the target advances after each byte. Every later data byte up to the next STOP or START is stored. The slave acknowledges by pulling SDA low through an open-drain enable output.

The eight registers drive the analog side as parallel buses: source select, input gain, surround, left and right attenuation, tone, output and bass limiter. A derived output gives the effective bass-limiter enable. It stays off whenever the bass field of the tone register asks for cut or flat, whatever the limiter register holds.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After a synchronous reset every control register reads 8'hFE, the effective limiter enable is 0, and SDA is released (sda_oe_o = 0).
- R2: The device address byte 8'h88 is acknowledged by driving SDA low during the ninth SCL clock. Any other address is not acknowledged, and the bytes that follow it up to the next START are neither acknowledged nor stored.
- R3: In the subaddress byte, bits [3:0] give the target register index and bit 4 is the auto-advance flag. Bits [7:5] have no effect.
- R4: With the auto-advance flag at 0, every data byte up to STOP is written to the same selected register.
- R5: With the auto-advance flag at 1, the first data byte goes to the selected index and each later byte goes to the index one higher.
- R6: Indices 8 to 15 store nothing and leave all registers unchanged. The auto-advancing index wraps from 15 back to 0, and the byte at that point goes to register 0.
- R7: Every data byte in an addressed transfer is acknowledged, including bytes aimed at indices 8 to 15.
- R8: The effective limiter enable is 1 only when bit 0 of the limiter register (index 7) is 1 and bit 7 of the tone register (index 5) is 1. Bass field [7:4] codes 0000 to 0111 mean cut or flat and force the enable to 0.
- R9: A STOP in the middle of a byte ends the transfer. The partial byte is discarded and bytes already written are kept.
- R10: A START at any point, including in the middle of a byte, restarts address matching, and the new transfer works normally.
- R11: A written register shows its new value on the outputs while SCL is high in that byte's acknowledge clock. Register outputs change only while SCL is high, and sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| src_sel_o | output | 8 | Register 0: input source select and mic |
| in_gain_o | output | 8 | Register 1: input gain |
| surround_o | output | 8 | Register 2: surround setup |
| vol_left_o | output | 8 | Register 3: left attenuation |
| vol_right_o | output | 8 | Register 4: right attenuation |
| tone_o | output | 8 | Register 5: treble [3:0], bass [7:4] |
| out_ctl_o | output | 8 | Register 6: output control |
| limiter_o | output | 8 | Register 7: bass limiter setup |
| limiter_en_o | output | 1 | Effective bass limiter enable |

## Verification
A wrong bit count or a bad phase in the byte engine shows up first as a missing or misplaced acknowledge. That happens within one byte time: SDA stays high in the ninth clock, or gets pulled low in a data clock. A wrong target index or a stale auto-advance flag reaches a register output by the acknowledge clock of the byte that is misdirected. Comparing all eight buses after every transfer catches stray writes, including writes that should have fallen into the unmapped indices. A bad abort path shows up when the next transfer either fails to be acknowledged or lands in the wrong register.

// File: rtl/acs_pkg.sv
// Shared constants and types for the audio control register slave.
// Assumes an 8-register map indexed by a 4-bit subaddress field.
package acs_pkg;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned REG_COUNT  = 8;
    localparam int unsigned SUB_W      = 4;
    localparam int unsigned AINC_BIT   = 4;
    localparam int unsigned TONE_IDX   = 5;
    localparam int unsigned LIM_IDX    = 7;
    localparam int unsigned LIM_EN_BIT = 0;
    localparam int unsigned BASS_MSB   = DATA_W - 1;
    localparam logic [DATA_W-1:0] DEV_ADDR = 8'h88;
    localparam logic [DATA_W-1:0] RST_VAL  = 8'hFE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA,
        ST_SKIP
    } acs_state_e;
endpackage

// File: rtl/acs_line_sync.sv
// Synchronises SCL and SDA into the system clock domain and reports
// SCL edges plus START and STOP conditions as one-cycle pulses.
// Assumes SCL and SDA stay at each level for more than STAGES+1 clocks.
module acs_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    // Synchroniser chains; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[STAGES-2:0], sda_i};
        end
    end

    // Previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_chain[LAST];
            sda_prev <= sda_chain[LAST];
        end
    end

    // Edge and condition decode from synchronised levels.
    always_comb begin
        scl_rise  = scl_chain[LAST] && !scl_prev;
        scl_fall  = !scl_chain[LAST] && scl_prev;
        start_det = scl_chain[LAST] && scl_prev && sda_prev && !sda_chain[LAST];
        stop_det  = scl_chain[LAST] && scl_prev && !sda_prev && sda_chain[LAST];
        sda_bit   = sda_chain[LAST];
    end
endmodule

// File: rtl/acs_xfer_engine.sv
// Byte engine: shifts in bits on SCL rise, matches the device address,
// decodes the subaddress byte, issues register write strobes and drives
// the acknowledge on the ninth clock. Assumes write-only transfers.
module acs_xfer_engine
    import acs_pkg::*;
#(
    parameter logic [DATA_W-1:0] ADDR = DEV_ADDR
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_bit,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [SUB_W-1:0] wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output acs_state_e       state_o
);
    localparam int unsigned CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(DATA_W);

    acs_state_e        state;
    logic [DATA_W-2:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic [SUB_W-1:0]  ptr;
    logic              ainc;
    logic              ack_arm;
    logic [DATA_W-1:0] byte_now;
    logic              active;
    logic              byte_done;

    // Byte being completed this cycle and whether the engine is shifting.
    always_comb begin
        byte_now  = {shreg, sda_bit};
        active    = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
        byte_done = scl_rise && active && (bit_cnt == LAST_BIT);
    end

    // Write strobe toward the register bank on the last data bit.
    always_comb begin
        wr_en   = byte_done && (state == ST_DATA);
        wr_idx  = ptr;
        wr_data = byte_now;
    end

    // Transfer state, bit counting, pointer and acknowledge control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            ptr     <= '0;
            ainc    <= 1'b0;
            ack_arm <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            ack_arm <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            ack_arm <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            if (scl_fall) begin
                sda_oe <= ack_arm && (bit_cnt == ACK_SLOT);
            end
            if (scl_rise && active) begin
                if (bit_cnt == ACK_SLOT) begin
                    bit_cnt <= '0;
                    ack_arm <= 1'b0;
                end else begin
                    shreg   <= byte_now[DATA_W-2:0];
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        unique case (state)
                            ST_ADDR: begin
                                if (byte_now == ADDR) begin
                                    state   <= ST_SUB;
                                    ack_arm <= 1'b1;
                                end else begin
                                    state   <= ST_SKIP;
                                end
                            end
                            ST_SUB: begin
                                ptr     <= byte_now[SUB_W-1:0];
                                ainc    <= byte_now[AINC_BIT];
                                state   <= ST_DATA;
                                ack_arm <= 1'b1;
                            end
                            ST_DATA: begin
                                ack_arm <= 1'b1;
                                if (ainc) begin
                                    ptr <= ptr + 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    assign state_o = state;
endmodule

// File: rtl/acs_reg_bank.sv
// Control register storage with a sparse index space: indices at or
// above REG_COUNT match no register. Also derives the effective bass
// limiter enable from the limiter bit and the bass field sign.
module acs_reg_bank
    import acs_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [SUB_W-1:0]                    wr_idx,
    input  logic [DATA_W-1:0]                   wr_data,
    output logic [REG_COUNT-1:0][DATA_W-1:0]    regs_o,
    output logic                                lim_eff_o
);
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        // One control register, loaded when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_o[g] <= RST_VAL;
            end else if (wr_en && (wr_idx == SUB_W'(g))) begin
                regs_o[g] <= wr_data;
            end
        end
    end

    // Limiter is allowed only when the bass field requests boost.
    always_comb begin
        lim_eff_o = regs_o[LIM_IDX][LIM_EN_BIT] && regs_o[TONE_IDX][BASS_MSB];
    end
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
// Top level of the write-only I2C control slave for an audio tone and
// volume processor. Connects the line synchroniser, the byte engine and
// the register bank. Assumes an external open-drain pad driven by sda_oe_o.
module audio_ctl_i2c_slave
    import acs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [DATA_W-1:0] src_sel_o,
    output logic [DATA_W-1:0] in_gain_o,
    output logic [DATA_W-1:0] surround_o,
    output logic [DATA_W-1:0] vol_left_o,
    output logic [DATA_W-1:0] vol_right_o,
    output logic [DATA_W-1:0] tone_o,
    output logic [DATA_W-1:0] out_ctl_o,
    output logic [DATA_W-1:0] limiter_o,
    output logic              limiter_en_o
);
    logic                             scl_rise;
    logic                             scl_fall;
    logic                             start_det;
    logic                             stop_det;
    logic                             sda_bit;
    logic                             wr_en;
    logic [SUB_W-1:0]                 wr_idx;
    logic [DATA_W-1:0]                wr_data;
    acs_state_e                       eng_state;
    logic [REG_COUNT-1:0][DATA_W-1:0] bank;

    acs_line_sync #(.STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit)
    );

    acs_xfer_engine #(.ADDR(DEV_ADDR)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .state_o   (eng_state)
    );

    acs_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .regs_o    (bank),
        .lim_eff_o (limiter_en_o)
    );

    // Fan the register array out to named buses.
    always_comb begin
        src_sel_o   = bank[0];
        in_gain_o   = bank[1];
        surround_o  = bank[2];
        vol_left_o  = bank[3];
        vol_right_o = bank[4];
        tone_o      = bank[TONE_IDX];
        out_ctl_o   = bank[6];
        limiter_o   = bank[LIM_IDX];
    end
endmodule

// File: rtl/audio_ctl_i2c_slave_chk.sv
// Protocol and register checks for audio_ctl_i2c_slave, bound to the top.
// Assumes SCL half periods much longer than the synchroniser latency.
module audio_ctl_i2c_slave_chk
    import acs_pkg::*;
(
    input logic                            clk,
    input logic                            rst_n,
    input logic                            scl_i,
    input logic                            sda_oe_o,
    input logic [REG_COUNT*DATA_W-1:0]     regs_flat,
    input logic [DATA_W-1:0]               tone,
    input logic [DATA_W-1:0]               limiter,
    input logic                            limiter_en,
    input logic                            wr_en,
    input logic [SUB_W-1:0]                wr_idx,
    input acs_state_e                      state
);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (regs_flat == {REG_COUNT{RST_VAL}}) && !sda_oe_o && !limiter_en);

    // R8
    bass_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tone[BASS_MSB] |-> !limiter_en);

    // R8
    lim_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !limiter[LIM_EN_BIT] |-> !limiter_en);

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) || $fell(sda_oe_o)) |-> !scl_i);

    // R11
    reg_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_flat) |-> scl_i);

    // R6
    sparse_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx[SUB_W-1]) |=> $stable(regs_flat));

    // R2
    ack_addressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_o |-> (state == ST_SUB || state == ST_DATA));
endmodule

bind audio_ctl_i2c_slave audio_ctl_i2c_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .regs_flat  ({limiter_o, out_ctl_o, tone_o, vol_right_o,
                  vol_left_o, surround_o, in_gain_o, src_sel_o}),
    .tone       (tone_o),
    .limiter    (limiter_o),
    .limiter_en (limiter_en_o),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .state      (eng_state)
);

// File: tb/audio_ctl_i2c_slave_test.sv
// Directed bench for audio_ctl_i2c_slave: a bit-banged I2C master over an
// open-drain line model, one task per scenario, with a register model.
module audio_ctl_i2c_slave_test;
    localparam int H = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [7:0] r0, r1, r2, r3, r4, r5, r6, r7;
    logic lim_en;
    logic [7:0] exp_r [8];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    audio_ctl_i2c_slave uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .src_sel_o    (r0),
        .in_gain_o    (r1),
        .surround_o   (r2),
        .vol_left_o   (r3),
        .vol_right_o  (r4),
        .tone_o       (r5),
        .out_ctl_o    (r6),
        .limiter_o    (r7),
        .limiter_en_o (lim_en)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] reg_of(input int i);
        case (i)
            0: return r0; 1: return r1; 2: return r2; 3: return r3;
            4: return r4; 5: return r5; 6: return r6; default: return r7;
        endcase
    endfunction

    task automatic check_regs(input string req);
        for (int i = 0; i < 8; i++) chk(req, reg_of(i), exp_r[i]);
        chk(req, lim_en, exp_r[7][0] & exp_r[5][7]);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(H);
        scl = 1'b1;   wait_clk(H);
        sda_m = 1'b0; wait_clk(H);
        scl = 1'b0;   wait_clk(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(H);
        scl = 1'b1;   wait_clk(H);
        sda_m = 1'b1; wait_clk(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wait_clk(H);
            scl = 1'b1;   wait_clk(H);
            scl = 1'b0;
        end
        wait_clk(H);
    endtask

    // Sends one byte; returns ACK seen and register snapshot in the ninth clock.
    task automatic send_byte(input logic [7:0] b, output logic ack, output logic [7:0] snap [8]);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(H);
            scl = 1'b1;   wait_clk(H);
            scl = 1'b0;
        end
        sda_m = 1'b1; wait_clk(H);
        scl = 1'b1;   wait_clk(H / 2);
        ack = ~sda_line;
        for (int i = 0; i < 8; i++) snap[i] = reg_of(i);
        wait_clk(H / 2);
        scl = 1'b0;   wait_clk(H);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) exp_r[i] = 8'hFE;
        check_regs("R1 reset values");
        chk("R1 sda released", sda_oe, 1'b0);
    endtask

    task automatic t_fixed_ptr();
        logic a;
        logic [7:0] s [8];
        bus_start();
        send_byte(8'h88, a, s); chk("R2 address ack", a, 1'b1);
        send_byte(8'hE3, a, s); chk("R3 subaddress ack", a, 1'b1);
        send_byte(8'h11, a, s); chk("R7 data ack", a, 1'b1);
        chk("R11 visible in ack clock", s[3], 8'h11);
        send_byte(8'h22, a, s); chk("R7 data ack", a, 1'b1);
        chk("R4 same register", s[3], 8'h22);
        bus_stop();
        exp_r[3] = 8'h22;
        check_regs("R3 R4 fixed target");
    endtask

    task automatic t_auto();
        logic a;
        logic [7:0] s [8];
        bus_start();
        send_byte(8'h88, a, s);
        send_byte(8'h14, a, s); chk("R3 subaddress ack", a, 1'b1);
        for (int i = 0; i < 4; i++) begin
            send_byte(8'hA0 + 8'(i), a, s);
            exp_r[4 + i] = 8'hA0 + 8'(i);
            chk("R5 auto advance", s[4 + i], exp_r[4 + i]);
        end
        for (int i = 0; i < 8; i++) begin
            send_byte(8'hC0 + 8'(i), a, s);
            chk("R7 ack unmapped", a, 1'b1);
            for (int k = 0; k < 8; k++) chk("R6 unmapped no store", s[k], exp_r[k]);
        end
        send_byte(8'h5A, a, s); exp_r[0] = 8'h5A;
        send_byte(8'h5B, a, s); exp_r[1] = 8'h5B;
        bus_stop();
        check_regs("R6 wrap to zero");
    endtask

    task automatic t_bad_addr();
        logic a;
        logic [7:0] s [8];
        bus_start();
        send_byte(8'h89, a, s); chk("R2 wrong address nack", a, 1'b0);
        send_byte(8'h00, a, s); chk("R2 ignored byte nack", a, 1'b0);
        send_byte(8'h33, a, s); chk("R2 ignored byte nack", a, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'h90, a, s); chk("R2 wrong address nack", a, 1'b0);
        bus_stop();
        check_regs("R2 nothing stored");
    endtask

    task automatic t_limiter();
        logic a;
        logic [7:0] s [8];
        bus_start();
        send_byte(8'h88, a, s);
        send_byte(8'h15, a, s);
        send_byte(8'h8F, a, s); exp_r[5] = 8'h8F;
        send_byte(8'h01, a, s); exp_r[6] = 8'h01;
        send_byte(8'h01, a, s); exp_r[7] = 8'h01;
        bus_stop();
        chk("R8 boost enables limiter", lim_en, 1'b1);
        check_regs("R8 limiter regs");
        bus_start();
        send_byte(8'h88, a, s);
        send_byte(8'h05, a, s);
        send_byte(8'h7F, a, s); exp_r[5] = 8'h7F;
        chk("R8 flat bass forces off", lim_en, 1'b0);
        send_byte(8'hF7, a, s); exp_r[5] = 8'hF7;
        chk("R8 boost again on", lim_en, 1'b1);
        bus_stop();
        bus_start();
        send_byte(8'h88, a, s);
        send_byte(8'h07, a, s);
        send_byte(8'hFE, a, s); exp_r[7] = 8'hFE;
        bus_stop();
        chk("R8 limiter bit off", lim_en, 1'b0);
    endtask

    task automatic t_abort();
        logic a;
        logic [7:0] s [8];
        bus_start();
        send_byte(8'h88, a, s);
        send_byte(8'h02, a, s);
        send_byte(8'h44, a, s); exp_r[2] = 8'h44;
        send_bits(8'h99, 4);
        bus_stop();
        check_regs("R9 stop mid byte");
        bus_start();
        send_byte(8'h88, a, s);
        send_byte(8'h01, a, s);
        send_bits(8'hFF, 3);
        bus_start();
        send_byte(8'h88, a, s); chk("R10 restart address ack", a, 1'b1);
        send_byte(8'h00, a, s);
        send_byte(8'h66, a, s); exp_r[0] = 8'h66;
        bus_stop();
        check_regs("R10 restart mid byte");
    endtask

    initial begin
        wait_clk(6);
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_fixed_ptr();
        t_auto();
        t_bad_addr();
        t_limiter();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule